// File: doc/BRIEF.md
# Setup-Masked Memory Window Register

This block is one memory base address register in a bridge's configuration space, paired with a setup register that fixes its shape. A loader writes the setup value while the host is locked out of configuration space. The setup value sets which base bits the host can write, whether the window is prefetchable, and whether the window exists at all. After the lockout is released, host configuration software sizes and places the window through the BAR. It writes all ones, reads back the masked value, then writes the chosen base.

On the transaction side, each incoming 32-bit memory address is compared against the programmed base under the setup mask. A registered forward-hit flag says whether the address falls inside the window. A setup mask that is not one run of ones starting at the top bit is flagged on an error output.

Top module: `mask_bar_decoder`

## Requirements
- R1: After reset the read data is 0, the hit output is 0 and the error output is 0. The setup value resets to all zeros, which means the window is disabled.
- R2: Read bit 0, bits 2:1 and bits 11:4 are always 0 in the BAR read data.
- R3: Read bit 3 equals setup bit 3 (1 means prefetchable) whenever the window is enabled and the host is not locked out.
- R4: A host write stores written bits 31:12 where the setup mask (setup bits 31:12) is 1 and stores 0 where it is 0. Read bits 31:12 return the stored base ANDed with the current mask.
- R5: When setup bit 31 is 0 the window is disabled, the BAR reads as all zeros and the hit output stays 0.
- R6: While the lockout input is 1, host reads return 0 and host writes leave the stored base unchanged.
- R7: A setup load takes effect only while the lockout input is 1. A load while unlocked leaves the setup value unchanged.
- R8: One cycle after a valid address, the hit output is 1 exactly when the window is enabled and (address[31:12] AND mask) equals (base AND mask).
- R9: The error output is 1 when the set bits of the setup mask are not one contiguous run ending at bit 31. An all-zero mask is not an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lockout | input | 1 | 1 blocks host configuration access and allows setup loads |
| setup_we | input | 1 | Setup load strobe |
| setup_wdata | input | 32 | Setup value: bits 31:12 mask (bit 31 enable), bit 3 prefetchable |
| cfg_we | input | 1 | Host BAR write strobe |
| cfg_wdata | input | 32 | Host BAR write data |
| cfg_rdata | output | 32 | Host BAR read data |
| addr_vld | input | 1 | Transaction address valid |
| addr | input | 32 | Transaction memory address |
| hit | output | 1 | Forward hit, one cycle after the address |
| cfg_err | output | 1 | Setup mask is not a contiguous run from bit 31 |

## Verification
A corrupted mask or base shows at once in the next read of cfg_rdata. It also shows one cycle after any valid address as a wrong hit, at the window edges most clearly. A lost enable shows as an all-zero readback together with a hit that never rises. A setup or base register that changes when the lockout forbids it shows on the first read or decoded address after the stray strobe. Random setup masks, including non-contiguous ones, are mixed with directed 4 KB, 2 GB and disabled windows so that each kind of fault reaches the ports within a few cycles.

// File: rtl/mbar_pkg.sv
package mbar_pkg;

   localparam int unsigned MAX_ADDR_W = 32;
   localparam int unsigned PF_BIT     = 3;

   // 1 when every set bit in the low n bits has all bits above it (up to n-1) set
   function automatic logic top_run_ok(logic [MAX_ADDR_W-1:0] m, int unsigned n);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < MAX_ADDR_W - 1; i++) begin
         if ((i + 1) < n && m[i] && !m[i+1]) ok = 1'b0;
      end
      return ok;
   endfunction

endpackage

// File: rtl/mbar_setup_reg.sv
module mbar_setup_reg
   import mbar_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned PAGE_LSB = 12,
   localparam int unsigned BASE_W  = ADDR_W - PAGE_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_i,
   input  logic              ld_i,
   input  logic [ADDR_W-1:0] ld_data_i,
   output logic [BASE_W-1:0] mask_o,
   output logic              en_o,
   output logic              pf_o,
   output logic              err_o
);

   logic [BASE_W-1:0] mask_q;
   logic              pf_q;
   logic              unused_ld;

   assign unused_ld = ^{ld_data_i[PAGE_LSB-1:PF_BIT+1], ld_data_i[PF_BIT-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         pf_q   <= 1'b0;
      end else if (ld_i && lock_i) begin
         mask_q <= ld_data_i[ADDR_W-1:PAGE_LSB];
         pf_q   <= ld_data_i[PF_BIT];
      end
   end

   assign mask_o = mask_q;
   assign en_o   = mask_q[BASE_W-1];
   assign pf_o   = pf_q;
   assign err_o  = !top_run_ok(MAX_ADDR_W'(mask_q), BASE_W);

   // R7
   setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_i |=> $stable(mask_q) && $stable(pf_q));

endmodule

// File: rtl/mbar_base_reg.sv
module mbar_base_reg #(
   parameter int unsigned BASE_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_i,
   input  logic              we_i,
   input  logic [BASE_W-1:0] wdata_i,
   input  logic [BASE_W-1:0] mask_i,
   output logic [BASE_W-1:0] base_o
);

   logic [BASE_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                base_q <= '0;
      else if (we_i && !lock_i)  base_q <= wdata_i & mask_i;
   end

   assign base_o = base_q;

   // R6
   base_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> $stable(base_q));

endmodule

// File: rtl/mbar_hit_cmp.sv
module mbar_hit_cmp #(
   parameter int unsigned BASE_W  = 20,
   parameter bit          REG_HIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [BASE_W-1:0] page_i,
   input  logic [BASE_W-1:0] base_i,
   input  logic [BASE_W-1:0] mask_i,
   input  logic              en_i,
   output logic              hit_o
);

   logic match;

   assign match = vld_i && en_i && (((page_i ^ base_i) & mask_i) == '0);

   generate
      if (REG_HIT) begin : g_reg
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= match;
         end
         assign hit_o = hit_q;

         // R8
         hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_q |-> $past(vld_i && en_i));
      end else begin : g_comb
         assign hit_o = match;
         // R5
         hit_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o |-> en_i && vld_i);
      end
   endgenerate

endmodule

// File: rtl/mask_bar_decoder.sv
module mask_bar_decoder
   import mbar_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned PAGE_LSB = 12,
   parameter bit          REG_HIT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lockout,
   input  logic              setup_we,
   input  logic [ADDR_W-1:0] setup_wdata,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   input  logic              addr_vld,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic              cfg_err
);

   localparam int unsigned BASE_W = ADDR_W - PAGE_LSB;
   localparam int unsigned GAP_W  = PAGE_LSB - PF_BIT - 1;

   generate
      if (ADDR_W > MAX_ADDR_W) begin : g_bad_width
         $error("mask_bar_decoder: ADDR_W above supported maximum");
      end
      if (PAGE_LSB < PF_BIT + 2 || PAGE_LSB >= ADDR_W) begin : g_bad_page
         $error("mask_bar_decoder: PAGE_LSB out of range");
      end
   endgenerate

   logic [BASE_W-1:0] mask;
   logic [BASE_W-1:0] base;
   logic              en;
   logic              pf;
   logic              unused_bits;

   assign unused_bits = ^{cfg_wdata[PAGE_LSB-1:0], addr[PAGE_LSB-1:0]};

   mbar_setup_reg #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_setup (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_i    (lockout),
      .ld_i      (setup_we),
      .ld_data_i (setup_wdata),
      .mask_o    (mask),
      .en_o      (en),
      .pf_o      (pf),
      .err_o     (cfg_err)
   );

   mbar_base_reg #(.BASE_W(BASE_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock_i  (lockout),
      .we_i    (cfg_we),
      .wdata_i (cfg_wdata[ADDR_W-1:PAGE_LSB]),
      .mask_i  (mask),
      .base_o  (base)
   );

   mbar_hit_cmp #(.BASE_W(BASE_W), .REG_HIT(REG_HIT)) u_hit (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (addr_vld),
      .page_i (addr[ADDR_W-1:PAGE_LSB]),
      .base_i (base),
      .mask_i (mask),
      .en_i   (en),
      .hit_o  (hit)
   );

   always_comb begin
      if (lockout || !en) cfg_rdata = '0;
      else cfg_rdata = {base & mask, {GAP_W{1'b0}}, pf, 3'b000};
   end

   // R6
   rd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |-> cfg_rdata == '0);

   // R2
   rd_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[2:0] == 3'b000 && cfg_rdata[PAGE_LSB-1:PF_BIT+1] == '0);

endmodule

// File: tb/sim_mask_bar_decoder.sv
module sim_mask_bar_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lockout = 1'b1;
   logic        setup_we = 1'b0;
   logic [31:0] setup_wdata = '0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        addr_vld = 1'b0;
   logic [31:0] addr = '0;
   logic        hit;
   logic        cfg_err;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [19:0] m_mask = '0;
   logic        m_pf   = 1'b0;
   logic [19:0] m_base = '0;

   always #4 clk = ~clk;

   mask_bar_decoder u0 (
      .clk(clk), .rst_n(rst_n), .lockout(lockout),
      .setup_we(setup_we), .setup_wdata(setup_wdata),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .addr_vld(addr_vld), .addr(addr), .hit(hit), .cfg_err(cfg_err)
   );

   function automatic logic [31:0] exp_rd();
      if (lockout || !m_mask[19]) return 32'h0;
      return {m_base & m_mask, 8'h00, m_pf, 3'b000};
   endfunction

   function automatic logic exp_err(logic [19:0] m);
      logic [19:0] inv;
      inv = ~m;
      return (inv & (inv + 20'd1)) != 20'd0;
   endfunction

   function automatic logic exp_hit(logic [31:0] a);
      return m_mask[19] && (((a[31:12] ^ m_base) & m_mask) == 20'd0);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_setup(logic [31:0] v);
      setup_we = 1'b1; setup_wdata = v;
      @(negedge clk);
      setup_we = 1'b0;
      if (lockout) begin m_mask = v[31:12]; m_pf = v[3]; end
      #1;
   endtask

   task automatic host_write(logic [31:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!lockout) m_base = v[31:12] & m_mask;
      #1;
   endtask

   task automatic probe(string req, logic [31:0] a, logic v);
      addr_vld = v; addr = a;
      @(negedge clk);
      addr_vld = 1'b0;
      #1;
      check(req, {31'b0, hit}, {31'b0, v && exp_hit(a)});
   endtask

   task automatic set_lock(logic l);
      lockout = l;
      #1;
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      check("R1 rdata", cfg_rdata, 32'h0);
      check("R1 hit", {31'b0, hit}, 32'h0);
      check("R1 err", {31'b0, cfg_err}, 32'h0);

      // locked: load 4 KB prefetchable window, reads blocked, writes ignored
      load_setup(32'hFFFF_F008);
      check("R6 locked read", cfg_rdata, 32'h0);
      host_write(32'hFFFF_FFFF);
      set_lock(1'b0);
      check("R6 write ignored while locked", cfg_rdata, 32'h0000_0008);
      check("R3 prefetch bit", cfg_rdata, exp_rd());
      host_write(32'hFFFF_FFFF);
      check("R4 size probe 4K", cfg_rdata, 32'hFFFF_F008);
      check("R2 fixed bits", cfg_rdata & 32'h0000_0FF7, 32'h0);
      host_write(32'h1234_5ABC);
      check("R4 base write", cfg_rdata, 32'h1234_5008);
      // R7 load while unlocked has no effect
      load_setup(32'h0000_0000);
      check("R7 unlocked load ignored", cfg_rdata, 32'h1234_5008);
      probe("R8 hit top of page", 32'h1234_5FFF, 1'b1);
      probe("R8 miss next page", 32'h1234_6000, 1'b1);
      probe("R8 miss below", 32'h1234_4FFF, 1'b1);
      probe("R8 no valid no hit", 32'h1234_5000, 1'b0);
      check("R9 no error 4K", {31'b0, cfg_err}, 32'h0);

      // 2 GB window, non-prefetchable
      set_lock(1'b1);
      load_setup(32'h8000_0000);
      set_lock(1'b0);
      host_write(32'hFFFF_FFFF);
      check("R4 size probe 2G", cfg_rdata, 32'h8000_0000);
      probe("R8 2G hit", 32'h9ABC_DEF0, 1'b1);
      probe("R8 2G miss", 32'h1ABC_DEF0, 1'b1);

      // disabled window
      set_lock(1'b1);
      load_setup(32'h0000_0008);
      set_lock(1'b0);
      host_write(32'hFFFF_FFFF);
      check("R5 disabled read", cfg_rdata, 32'h0);
      probe("R5 disabled no hit", 32'hFFFF_F000, 1'b1);
      probe("R5 disabled no hit zero", 32'h0000_0000, 1'b1);
      check("R9 zero mask no error", {31'b0, cfg_err}, 32'h0);

      // non-contiguous mask
      set_lock(1'b1);
      load_setup(32'hFF0F_F000);
      check("R9 hole in mask", {31'b0, cfg_err}, 32'h1);
      load_setup(32'h7FFF_F000);
      check("R9 top bit clear", {31'b0, cfg_err}, 32'h1);
      set_lock(1'b0);
      check("R5 top bit clear read", cfg_rdata, 32'h0);

      // constrained random
      for (int it = 0; it < 300; it++) begin
         logic [31:0] sv;
         set_lock(1'b1);
         if ($urandom_range(0, 3) == 0) sv = $urandom;
         else begin
            int ones;
            ones = $urandom_range(0, 20);
            sv = (ones == 0) ? 32'h0 : ~((32'h1 << (32 - ones)) - 32'h1);
            sv[3] = $urandom_range(0, 1) == 1;
         end
         load_setup(sv);
         check("R9 random mask", {31'b0, cfg_err}, {31'b0, exp_err(m_mask)});
         if ($urandom_range(0, 1) == 1) host_write($urandom);
         check("R6 random locked read", cfg_rdata, 32'h0);
         set_lock(1'b0);
         for (int k = 0; k < 4; k++) begin
            logic [31:0] a;
            case ($urandom_range(0, 3))
               0: host_write($urandom);
               1: load_setup($urandom);
               default: ;
            endcase
            check("R4 random read", cfg_rdata, exp_rd());
            a = ($urandom_range(0, 1) == 1) ? {m_base, 12'(0)} | ($urandom & 32'h0000_0FFF) : $urandom;
            probe("R8 random hit", a, $urandom_range(0, 3) != 0);
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule